// File: doc/BRIEF.md
# Autonegotiation Result Validator

This block watches an Ethernet PHY after the PHY says that autonegotiation has finished, and decides whether to trust the link-partner ability word it reports. Finishing is not taken as the final answer. The block runs three checks on the words the PHY offers:

- the partner ability word,
- the expansion word,
- a status word read from a hidden register bank.

If any check fails, the block pulses a restart request to the negotiation logic and counts the retry. It then waits for the done flag to fall and rise again before it checks a second time.

An accepted result raises a valid flag and clears the retry count. After six restarts, a further rejection raises a give-up flag, and no more restarts are requested. Lowering `enable` returns the block to idle and clears everything.

The controller is a Moore state machine with seven states:

| State | What it does | Next state |
|---|---|---|
| IDLE | Waits for `enable`. | WAIT_DONE when `enable` is high |
| WAIT_DONE | Waits for `aneg_done`. | EVAL when `aneg_done` is high |
| EVAL | Classifies the three words. | GOOD when accepted; RESTART when rejected below the limit; FAIL when rejected at the limit |
| RESTART | Drives the one-cycle restart pulse. | WAIT_DROP on the next clock |
| WAIT_DROP | Waits for `aneg_done` to fall. | WAIT_DONE when `aneg_done` falls |
| GOOD | Holds the valid flag. | WAIT_DONE when `aneg_done` falls (link lost) |
| FAIL | Holds the give-up flag. | Stays in FAIL |

From any state, a low `enable` forces IDLE.

Top module: `aneg_result_validator`

## Requirements
- R1: While `enable` is low, `restart_pulse`, `result_valid` and `give_up` stay 0 and `retry_count` stays 0, whatever `aneg_done` and the words do.
- R2: A result is rejected when bit 12 of `hidden_status` is 0.
- R3: A result is rejected when bit 0 of `expansion_word` is 1 (partner can negotiate) and bit 14 of `partner_word` (acknowledge) is 0.
- R4: A result is rejected when `partner_word` equals 16'h0001, whatever `expansion_word` holds.
- R5: Otherwise the result is accepted. `result_valid` rises two clocks after `aneg_done` is seen high in WAIT_DONE. It stays high until `aneg_done` falls.
- R6: A rejection below the limit drives `restart_pulse` high for exactly one cycle, two clocks after `aneg_done` is seen. In that same cycle, `retry_count` goes up by one.
- R7: After a restart, no new evaluation or restart happens while `aneg_done` stays high. Evaluation resumes only after `aneg_done` falls and rises again.
- R8: A rejection when `retry_count` is already 6 raises `give_up` instead of a restart. `give_up` then holds, and no restart is issued while `enable` stays high.
- R9: An accepted result sets `retry_count` to 0.
- R10: One clock after `enable` falls, all outputs return to 0.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Autonegotiation enabled; low forces idle |
| aneg_done | input | 1 | PHY reports negotiation complete |
| partner_word | input | 16 | Link-partner ability word |
| expansion_word | input | 16 | Expansion word |
| hidden_status | input | 16 | Status word from the hidden bank |
| restart_pulse | output | 1 | One-cycle request to restart negotiation |
| result_valid | output | 1 | Reported result accepted |
| give_up | output | 1 | Retry limit exhausted |
| retry_count | output | 3 | Restarts issued since the last accept or idle |

## Verification
A verdict appears two clocks after `aneg_done` is presented in WAIT_DONE: one edge to enter EVAL and one edge to enter GOOD, RESTART or FAIL. `retry_count` changes on that same second edge. The bench drives its inputs on falling edges and samples exactly two falling edges after raising `aneg_done`. A `enable` drop is checked one falling edge later. Windows where a rule forbids any output (disabled, holding after a restart, given up) are checked on every cycle across several clocks.

// File: rtl/anv_pkg.sv
package anv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DONE,
        ST_EVAL,
        ST_RESTART,
        ST_WAIT_DROP,
        ST_GOOD,
        ST_FAIL
    } anv_state_e;

    typedef struct packed {
        logic stat_clear;   // hidden status bit not set
        logic no_ack;       // partner capable but no acknowledge
        logic early;        // partner word is the early-failure code
    } anv_reason_t;

endpackage

// File: rtl/anv_verdict.sv
module anv_verdict
    import anv_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          STAT_BIT   = 12,
    parameter int          ACK_BIT    = 14,
    parameter int          NWAY_BIT   = 0,
    parameter logic [15:0] EARLY_CODE = 16'h0001
) (
    input  logic [WORD_W-1:0] partner_word,
    input  logic [WORD_W-1:0] expansion_word,
    input  logic [WORD_W-1:0] hidden_status,
    output anv_reason_t       reason,
    output logic              reject
);

    localparam logic [WORD_W-1:0] EARLY_W = WORD_W'(EARLY_CODE);

    always_comb begin
        reason.stat_clear = ~hidden_status[STAT_BIT];
        reason.no_ack     = expansion_word[NWAY_BIT] & ~partner_word[ACK_BIT];
        reason.early      = (partner_word == EARLY_W);
        reject            = |reason;
    end

endmodule

// File: rtl/anv_retry_ctr.sv
module anv_retry_ctr #(
    parameter int MAX_RETRY = 6,
    parameter int CNT_W     = $clog2(MAX_RETRY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != LIMIT) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == LIMIT);

endmodule

// File: rtl/anv_fsm.sv
module anv_fsm
    import anv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic aneg_done,
    input  logic reject,
    input  logic at_limit,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic restart_pulse,
    output logic result_valid,
    output logic give_up
);

    anv_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        if (!enable) begin
            state_nx = ST_IDLE;
            cnt_clr  = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_WAIT_DONE;
                ST_WAIT_DONE: if (aneg_done) state_nx = ST_EVAL;
                ST_EVAL: begin
                    if (!reject) begin
                        state_nx = ST_GOOD;
                        cnt_clr  = 1'b1;
                    end else if (at_limit) begin
                        state_nx = ST_FAIL;
                    end else begin
                        state_nx = ST_RESTART;
                        cnt_inc  = 1'b1;
                    end
                end
                ST_RESTART:   state_nx = ST_WAIT_DROP;
                ST_WAIT_DROP: if (!aneg_done) state_nx = ST_WAIT_DONE;
                ST_GOOD:      if (!aneg_done) state_nx = ST_WAIT_DONE;
                ST_FAIL:      state_nx = ST_FAIL;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        restart_pulse = 1'b0;
        result_valid  = 1'b0;
        give_up       = 1'b0;
        unique case (state)
            ST_RESTART: restart_pulse = 1'b1;
            ST_GOOD:    result_valid  = 1'b1;
            ST_FAIL:    give_up       = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/aneg_result_validator.sv
module aneg_result_validator
    import anv_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          MAX_RETRY  = 6,
    parameter int          STAT_BIT   = 12,
    parameter int          ACK_BIT    = 14,
    parameter int          NWAY_BIT   = 0,
    parameter logic [15:0] EARLY_CODE = 16'h0001,
    localparam int         CNT_W      = $clog2(MAX_RETRY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              aneg_done,
    input  logic [WORD_W-1:0] partner_word,
    input  logic [WORD_W-1:0] expansion_word,
    input  logic [WORD_W-1:0] hidden_status,
    output logic              restart_pulse,
    output logic              result_valid,
    output logic              give_up,
    output logic [CNT_W-1:0]  retry_count
);

    anv_reason_t reason;
    logic        reject, at_limit, cnt_clr, cnt_inc;

    anv_verdict #(
        .WORD_W(WORD_W), .STAT_BIT(STAT_BIT), .ACK_BIT(ACK_BIT),
        .NWAY_BIT(NWAY_BIT), .EARLY_CODE(EARLY_CODE)
    ) u_verdict (
        .partner_word(partner_word),
        .expansion_word(expansion_word),
        .hidden_status(hidden_status),
        .reason(reason),
        .reject(reject)
    );

    anv_retry_ctr #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .count(retry_count), .at_limit(at_limit)
    );

    anv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .aneg_done(aneg_done),
        .reject(reject), .at_limit(at_limit),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .restart_pulse(restart_pulse), .result_valid(result_valid),
        .give_up(give_up)
    );

endmodule

// File: rtl/aneg_result_validator_chk.sv
module aneg_result_validator_chk #(
    parameter int MAX_RETRY = 6,
    localparam int CNT_W    = $clog2(MAX_RETRY + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             restart_pulse,
    input logic             result_valid,
    input logic             give_up,
    input logic [CNT_W-1:0] retry_count
);

    // R6
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);

    // R6
    restart_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_pulse) |-> retry_count == $past(retry_count) + 1'b1);

    // R8
    giveup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        give_up |-> !restart_pulse && !result_valid);

    // R8
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_count <= CNT_W'(MAX_RETRY));

    // R9
    valid_zero_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> retry_count == '0);

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !restart_pulse && !result_valid && !give_up && retry_count == '0);

endmodule

bind aneg_result_validator aneg_result_validator_chk #(.MAX_RETRY(MAX_RETRY)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .restart_pulse(restart_pulse), .result_valid(result_valid),
    .give_up(give_up), .retry_count(retry_count)
);

// File: tb/sim_aneg_result_validator.sv
`timescale 1ns/1ps
module sim_aneg_result_validator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        aneg_done = 1'b0;
    logic [15:0] partner_word = '0;
    logic [15:0] expansion_word = '0;
    logic [15:0] hidden_status = '0;
    logic        restart_pulse, result_valid, give_up;
    logic [2:0]  retry_count;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    aneg_result_validator u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .aneg_done(aneg_done),
        .partner_word(partner_word), .expansion_word(expansion_word),
        .hidden_status(hidden_status), .restart_pulse(restart_pulse),
        .result_valid(result_valid), .give_up(give_up), .retry_count(retry_count)
    );

    // {hidden_status, expansion_word, partner_word, accept}
    localparam logic [48:0] VEC [0:8] = '{
        {16'h1000, 16'h0001, 16'h45E1, 1'b1},  // R5 clean
        {16'h0000, 16'h0001, 16'h45E1, 1'b0},  // R2
        {16'hEFFF, 16'h0001, 16'hFFFF, 1'b0},  // R2 only bit 12 clear
        {16'h1000, 16'h0001, 16'h05E1, 1'b0},  // R3
        {16'h1000, 16'h0000, 16'h05E1, 1'b1},  // R3 partner not capable
        {16'h1000, 16'h0000, 16'h0001, 1'b0},  // R4
        {16'h1000, 16'h0001, 16'h4001, 1'b1},  // R4 not exact code
        {16'h1000, 16'hFFFE, 16'h0000, 1'b1},  // R5
        {16'hFFFF, 16'h0000, 16'h0001, 1'b0}   // R4
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic fresh();
        enable = 1'b0; aneg_done = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic present(input logic [15:0] h, input logic [15:0] e, input logic [15:0] p);
        hidden_status = h; expansion_word = e; partner_word = p;
        aneg_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drop();
        aneg_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk("R11 restart", 16'(restart_pulse), 16'h0);
        chk("R11 valid", 16'(result_valid), 16'h0);
        chk("R11 give_up", 16'(give_up), 16'h0);
        chk("R11 retry", 16'(retry_count), 16'h0);

        // table walk
        for (int i = 0; i < 9; i++) begin
            fresh();
            present(VEC[i][48:33], VEC[i][32:17], VEC[i][16:1]);
            chk($sformatf("R5/R6 vec%0d valid", i), 16'(result_valid), 16'(VEC[i][0]));
            chk($sformatf("R2/R3/R4 vec%0d restart", i), 16'(restart_pulse), 16'(!VEC[i][0]));
            chk($sformatf("R6 vec%0d retry", i), 16'(retry_count), VEC[i][0] ? 16'h0 : 16'h1);
            drop();
        end

        // R1: disabled, bad words with done high
        enable = 1'b0;
        hidden_status = 16'h0; expansion_word = 16'h1; partner_word = 16'h1;
        aneg_done = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R1 restart", 16'(restart_pulse), 16'h0);
            chk("R1 valid", 16'(result_valid), 16'h0);
        end

        // R6/R7: single pulse, hold while done stays high
        fresh();
        present(16'h0000, 16'h0001, 16'h45E1);
        chk("R6 pulse", 16'(restart_pulse), 16'h1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R7 no pulse", 16'(restart_pulse), 16'h0);
            chk("R7 retry held", 16'(retry_count), 16'h1);
        end
        drop();
        present(16'h0000, 16'h0001, 16'h45E1);
        chk("R7 reeval", 16'(restart_pulse), 16'h1);
        chk("R6 second retry", 16'(retry_count), 16'h2);
        drop();
        present(16'h1000, 16'h0001, 16'h45E1);
        chk("R9 valid", 16'(result_valid), 16'h1);
        chk("R9 retry cleared", 16'(retry_count), 16'h0);
        @(negedge clk);
        chk("R5 valid held", 16'(result_valid), 16'h1);
        drop();
        chk("R5 valid falls", 16'(result_valid), 16'h0);

        // R8: limit
        fresh();
        for (int r = 1; r <= 6; r++) begin
            present(16'h1000, 16'h0000, 16'h0001);
            chk($sformatf("R8 restart %0d", r), 16'(restart_pulse), 16'h1);
            chk($sformatf("R8 retry %0d", r), 16'(retry_count), 16'(r));
            drop();
        end
        present(16'h1000, 16'h0000, 16'h0001);
        chk("R8 give_up", 16'(give_up), 16'h1);
        chk("R8 no restart", 16'(restart_pulse), 16'h0);
        chk("R8 retry at limit", 16'(retry_count), 16'h6);
        drop();
        present(16'h1000, 16'h0001, 16'h45E1);
        chk("R8 give_up holds", 16'(give_up), 16'h1);
        chk("R8 no valid", 16'(result_valid), 16'h0);

        // R10
        enable = 1'b0;
        @(negedge clk);
        chk("R10 give_up", 16'(give_up), 16'h0);
        chk("R10 retry", 16'(retry_count), 16'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule